// File: doc/BRIEF.md
# Paged DMA Transfer Address Generator

This block produces the 24-bit physical address for one DMA channel while a transfer runs. The address is built from an 8-bit page value and a 16-bit address counter. A 16-bit counter holds the number of transfers minus one. Each transfer strobe moves the channel forward by one unit, and the block raises a terminal-count pulse on the last unit. In byte mode each unit is one byte. In word mode each unit is one 16-bit word: the counter is shifted left by one place and the page bit 0 is dropped.

The address counter wraps within its own 16 bits and never carries into the page. A transfer therefore stays inside one 64K region in byte mode, or one 128K region in word mode. One programming moves up to 65536 units. A start strobe copies a start address and a start count into the counters. The channel then runs until terminal count. At that point it either stops and flags completion, or, when auto-initialize is set, reloads from the base address and base count and keeps going. The remaining count is always visible as the residue.

Top module: `dma_addr_gen`

## Requirements
- R1: In byte mode (wordMode=0), physAddr[23:16] equals pageReg and physAddr[15:0] equals the address counter.
- R2: In word mode (wordMode=1), physAddr[23:17] equals pageReg[7:1], physAddr[16:1] equals the address counter, and physAddr[0] is 0. The value of pageReg[0] has no effect on any output.
- R3: A strobe with the address counter at 0xFFFF takes it to 0x0000. The page bits of physAddr do not change.
- R4: Each accepted strobe lowers the count (residue) by one. termCount is high, in the same cycle as the strobe, exactly when an accepted strobe arrives with the count at 0x0000.
- R5: byteEn is 2'b11 in word mode. In byte mode it is 2'b01 when physAddr[0]=0 and 2'b10 when physAddr[0]=1.
- R6: On terminal count with autoInit=0, the next cycle shows active=0, done=1 and residue=0xFFFF. The address counter has still advanced by one.
- R7: On terminal count with autoInit=1, the next cycle shows the address counter equal to baseAddr, residue equal to baseCount, active=1 and done=0.
- R8: A strobe is accepted only while active=1. A strobe while inactive leaves the address, residue and done unchanged.
- R9: loadStb sets the address counter to startAddr and residue to startCount, sets active=1 and clears done. If loadStb and xferStb are high in the same cycle, the load wins: no termCount is raised and no step is taken.
- R10: After reset the address counter is 0x0000, residue is 0xFFFF, and active, done and termCount are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Load start address and start count, then arm the channel |
| startAddr | input | 16 | Address counter value used by loadStb |
| startCount | input | 16 | Transfers minus one, used by loadStb |
| baseAddr | input | 16 | Address reloaded at terminal count when autoInit is set |
| baseCount | input | 16 | Count reloaded at terminal count when autoInit is set |
| pageReg | input | 8 | Page value giving the upper physical bits |
| wordMode | input | 1 | 1 = 16-bit units, 0 = byte units |
| autoInit | input | 1 | Reload from the base values at terminal count |
| xferStb | input | 1 | One unit transferred this cycle |
| physAddr | output | 24 | Physical address of the current unit |
| byteEn | output | 2 | Byte lanes for the current unit |
| termCount | output | 1 | High during the strobe of the last unit |
| active | output | 1 | Channel armed and accepting strobes |
| done | output | 1 | Transfer finished without auto-initialize |
| residue | output | 16 | Current count (transfers remaining minus one) |

## Verification
Two events can fall in the same cycle, and both are provoked on purpose. The first is a load that arrives together with a transfer strobe while the count is at zero, so termCount, the stop and the load all compete. The second is terminal count under auto-initialize, where the step and the reload meet. A behavioural model in the bench resolves each collision from the requirements: the load beats the step, and the reload beats the increment. The bench compares every output against that model on each clock, so a wrong priority shows up as a mismatch in the very next cycle.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef struct packed {
    logic load;    // take start values, arm the channel
    logic step;    // accepted transfer, advance by one unit
    logic reload;  // terminal count under auto-initialize
  } dmaStrobe_t;
endpackage

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl
  import dma_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       xferStb,
  input  logic       autoInit,
  input  logic       countZero,
  output dmaStrobe_t st,
  output logic       termCount,
  output logic       active,
  output logic       done
);
  logic stepOk;

  always_comb begin
    stepOk    = xferStb && active && !loadStb;
    termCount = stepOk && countZero;
    st.load   = loadStb;
    st.step   = stepOk;
    st.reload = termCount && autoInit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      done   <= 1'b0;
    end else if (loadStb) begin
      active <= 1'b1;
      done   <= 1'b0;
    end else if (termCount && !autoInit) begin
      active <= 1'b0;
      done   <= 1'b1;
    end
  end

  p_stop_at_tc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (termCount && !autoInit) |=> (done && !active));

  p_load_arms_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (active && !done));

  p_tc_only_when_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !termCount);
endmodule

// File: rtl/dma_addr_dp.sv
module dma_addr_dp
  import dma_addr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        st,
  input  logic [CNT_W-1:0]  startAddr,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [CNT_W-1:0]  baseAddr,
  input  logic [CNT_W-1:0]  baseCount,
  input  logic [PAGE_W-1:0] pageReg,
  input  logic              wordMode,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        byteEn,
  output logic              countZero,
  output logic [CNT_W-1:0]  residue
);
  logic [CNT_W-1:0] addrQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '1;
    end else if (st.load) begin
      addrQ <= startAddr;
      cntQ  <= startCount;
    end else if (st.reload) begin
      addrQ <= baseAddr;
      cntQ  <= baseCount;
    end else if (st.step) begin
      addrQ <= addrQ + 1'b1;
      cntQ  <= cntQ - 1'b1;
    end
  end

  always_comb begin
    if (wordMode) begin
      physAddr = {pageReg[PAGE_W-1:1], addrQ, 1'b0};
      byteEn   = 2'b11;
    end else begin
      physAddr = {pageReg, addrQ};
      byteEn   = addrQ[0] ? 2'b10 : 2'b01;
    end
    countZero = (cntQ == '0);
    residue   = cntQ;
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && !st.reload && !st.load) |=> (cntQ == $past(cntQ) - 1'b1));

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && !st.reload && !st.load && addrQ == '1) |=> (addrQ == '0));

  p_reload_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.reload && !st.load) |=> (addrQ == $past(baseAddr) && cntQ == $past(baseCount)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && !st.step && !st.reload) |=> ($stable(addrQ) && $stable(cntQ)));

  p_one_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wordMode |-> ($countones(byteEn) == 1));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [CNT_W-1:0]  startAddr,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [CNT_W-1:0]  baseAddr,
  input  logic [CNT_W-1:0]  baseCount,
  input  logic [PAGE_W-1:0] pageReg,
  input  logic              wordMode,
  input  logic              autoInit,
  input  logic              xferStb,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        byteEn,
  output logic              termCount,
  output logic              active,
  output logic              done,
  output logic [CNT_W-1:0]  residue
);
  dmaStrobe_t st;
  logic       countZero;

  dma_addr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStb   (loadStb),
    .xferStb   (xferStb),
    .autoInit  (autoInit),
    .countZero (countZero),
    .st        (st),
    .termCount (termCount),
    .active    (active),
    .done      (done)
  );

  dma_addr_dp #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .startAddr  (startAddr),
    .startCount (startCount),
    .baseAddr   (baseAddr),
    .baseCount  (baseCount),
    .pageReg    (pageReg),
    .wordMode   (wordMode),
    .physAddr   (physAddr),
    .byteEn     (byteEn),
    .countZero  (countZero),
    .residue    (residue)
  );
endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] startAddr = '0, startCount = '0, baseAddr = '0, baseCount = '0;
  logic [7:0]  pageReg = '0;
  logic        wordMode = 1'b0, autoInit = 1'b0, xferStb = 1'b0;
  logic [23:0] physAddr;
  logic [1:0]  byteEn;
  logic        termCount, active, done;
  logic [15:0] residue;

  int checks = 0;
  int fails = 0;
  string scen = "R10";

  // behavioural model state
  logic [15:0] mAddr = 16'h0000;
  logic [15:0] mCnt = 16'hFFFF;
  bit          mActive = 0;
  bit          mDone = 0;

  always #5 clk = ~clk;

  dma_addr_gen u_dma_addr_gen (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .startAddr(startAddr),
    .startCount(startCount), .baseAddr(baseAddr), .baseCount(baseCount),
    .pageReg(pageReg), .wordMode(wordMode), .autoInit(autoInit),
    .xferStb(xferStb), .physAddr(physAddr), .byteEn(byteEn),
    .termCount(termCount), .active(active), .done(done), .residue(residue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (scenario %s) at %0t: actual %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [23:0] ePhys;
    logic [1:0]  eBe;
    bit          eTc;
    ePhys = wordMode ? {pageReg[7:1], mAddr, 1'b0} : {pageReg, mAddr};
    eBe   = wordMode ? 2'b11 : (mAddr[0] ? 2'b10 : 2'b01);
    eTc   = xferStb && mActive && !loadStb && (mCnt == 16'h0000);
    chk(wordMode ? "R2 physAddr" : "R1 physAddr", {8'h0, physAddr}, {8'h0, ePhys});
    chk("R5 byteEn", {30'h0, byteEn}, {30'h0, eBe});
    chk("R4 termCount", {31'h0, termCount}, {31'h0, eTc});
    chk("R4 residue", {16'h0, residue}, {16'h0, mCnt});
    chk("R6 active", {31'h0, active}, {31'h0, mActive});
    chk("R6 done", {31'h0, done}, {31'h0, mDone});
  endtask

  task automatic modelEdge();
    if (loadStb) begin
      mAddr = startAddr; mCnt = startCount; mActive = 1; mDone = 0;
    end else if (xferStb && mActive) begin
      if (mCnt == 16'h0000 && autoInit) begin
        mAddr = baseAddr; mCnt = baseCount;
      end else begin
        if (mCnt == 16'h0000) begin mActive = 0; mDone = 1; end
        mAddr = mAddr + 16'h1;
        mCnt  = mCnt - 16'h1;
      end
    end
  endtask

  // inputs already set after a negedge: compare, then advance through one edge
  task automatic cyc(input bit ld, input bit stb);
    loadStb = ld; xferStb = stb;
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    loadStb = 1'b0; xferStb = 1'b0;
  endtask

  task automatic arm(input logic [15:0] a, input logic [15:0] c);
    startAddr = a; startCount = c;
    cyc(1'b1, 1'b0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired at %0t: actual hung expected finished", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pageReg = 8'h5A;
    #22;
    // R10: reset values before release
    compareAll();
    rstN = 1'b1;
    @(negedge clk);
    cyc(1'b0, 1'b0);

    // R8: strobes before any load are ignored
    scen = "R8";
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    // R1/R4/R6: byte mode, four units, idle gaps in between
    scen = "R1";
    arm(16'h1234, 16'h0003);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    scen = "R6";
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    chk("R6 residue after stop", {16'h0, residue}, 32'h0000FFFF);
    chk("R6 addr advanced", {8'h0, physAddr}, 32'h005A1238);
    scen = "R8";
    cyc(1'b0, 1'b1);
    chk("R8 addr unchanged", {8'h0, physAddr}, 32'h005A1238);

    // R2/R3: word mode, odd page, wrap of the address counter
    scen = "R3";
    wordMode = 1'b1; pageReg = 8'h5B;
    arm(16'hFFFE, 16'h0004);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);
    chk("R3 word wrap stays in page", {8'h0, physAddr}, {8'h0, 7'h2D, 16'h0003, 1'b0});
    pageReg = 8'h5A;
    cyc(1'b0, 1'b0);
    chk("R2 page bit0 ignored", {8'h0, physAddr}, {8'h0, 7'h2D, 16'h0003, 1'b0});

    // R3/R5: byte mode wrap with odd and even lanes
    wordMode = 1'b0; pageReg = 8'h0C;
    arm(16'hFFFD, 16'h0005);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
    chk("R3 byte wrap stays in page", {8'h0, physAddr}, 32'h000C0001);

    // R7: auto-initialize reload, twice through
    scen = "R7";
    autoInit = 1'b1; baseAddr = 16'h0100; baseCount = 16'h0001;
    arm(16'h0200, 16'h0000);
    cyc(1'b0, 1'b1);
    chk("R7 reload address", {8'h0, physAddr}, 32'h000C0100);
    chk("R7 reload count", {16'h0, residue}, 32'h00000001);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);
    chk("R7 still active", {31'h0, active}, 32'h1);

    // R9: load colliding with a terminal-count strobe
    scen = "R9";
    autoInit = 1'b0;
    arm(16'h4000, 16'h0000);
    startAddr = 16'h7777; startCount = 16'h0002;
    loadStb = 1'b1; xferStb = 1'b1;
    #1;
    chk("R9 no termCount on load", {31'h0, termCount}, 32'h0);
    cyc(1'b1, 1'b1);
    chk("R9 load wins address", {8'h0, physAddr}, 32'h000C7777);
    chk("R9 load wins count", {16'h0, residue}, 32'h00000002);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);

    // R10: reset in the middle of a run
    scen = "R10";
    arm(16'h0ABC, 16'h0010);
    cyc(1'b0, 1'b1);
    rstN = 1'b0;
    mAddr = 16'h0000; mCnt = 16'hFFFF; mActive = 0; mDone = 0;
    #1;
    compareAll();
    @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule